// File: doc/BRIEF.md
# Positive-Justification Frame Multiplexer

This block combines four serial tributaries into one high-speed serial frame by positive bit justification. Each tributary pushes bits into its own 8-entry elastic store as a valid/ready stream. A frame timer clocked by the high-speed clock walks the frame. The frame holds an alignment word, an alarm bit, a national bit, data sections interleaved by tributary, three groups of justification indicators and one group of stuff-opportunity slots. The serial frame leaves as a valid/ready stream, and each bit goes out as the output register accepts it.

Once per frame, at the moment its first bit is loaded, the block compares the fill of each store against half depth. A tributary whose store is below half is stuffed. Its opportunity slot then carries that tributary's auxiliary bit, and its three indicator bits are all 1. Any other tributary gives up one more data bit in that slot, and its indicators are 0. The mode input selects a short frame of 848 bits or a long frame of 1536 bits. Each frame is built from four equal quarters of 212 or 384 bits.

Back-pressure rules: `trib_ready[i]` is low only while store i holds 8 bits. A bit offered with `trib_valid[i]` high while ready is low is dropped and sets the sticky overflow flag, because a tributary cannot be stalled. On the output side, `out_data` and `out_sync` are held while `out_valid` is high and `out_ready` is low, and the frame does not advance. Once the first bit is loaded after reset, `out_valid` stays high.

Top module: `jm_frame_mux`

## Requirements
- R1: `mode_long` low gives a frame of 848 bits and high gives a frame of 1536 bits. The input is sampled only when bit 1 of a frame is loaded into the output register, so a change in mid-frame takes effect at the next frame.
- R2: Bits 1 to 10 of every frame carry the alignment word 1111010000, with the leftmost bit sent first.
- R3: Bit 11 carries `alarm_bit` and bit 12 carries `national_bit`, each taken in the cycle that bit is loaded.
- R4: `out_sync` is high together with the last bit of each frame and low with every other bit.
- R5: With quarter length L (212 short, 384 long), data fills bits 13..L, L+5..2L, 2L+5..3L and 3L+9..4L. The bit at position p belongs to tributary (p-1) mod 4, and each tributary's data bits leave in the order its store accepted them.
- R6: The indicator bits at L+1..L+4, 2L+1..2L+4 and 3L+1..3L+4 are 1 for a tributary stuffed in the current frame and 0 otherwise. Bit (p-1) mod 4 of each group belongs to the tributary with that index.
- R7: When bit 1 is loaded, each tributary whose store holds fewer than 4 bits is marked stuffed. `stuff_status[i]` shows this decision from that same edge until the next frame. The opportunity slot at 3L+5..3L+8 carries `aux_bit[i]` if tributary i is stuffed, and otherwise carries the next data bit from its store.
- R8: While `force_ones[i]` is high, every data bit of tributary i is sent as 1. This includes an unstuffed opportunity slot. Its store is still read as usual.
- R9: Each store starts after reset with 4 bits of value 0. `trib_ready[i]` is low exactly when the store holds 8 bits. A bit offered while ready is low is dropped and sets the sticky `ovf_flag[i]`.
- R10: A data read from an empty store sends 1 and sets the sticky `udf_flag[i]`.
- R11: `out_valid` is low during reset and goes high on the first clock after it, then stays high. While `out_ready` is low, `out_data` and `out_sync` hold and the frame does not advance.
- R12: During reset, `out_valid`, `out_sync`, `stuff_status`, `ovf_flag` and `udf_flag` are 0 and `trib_ready` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_long | input | 1 | 0 selects the 848-bit frame, 1 the 1536-bit frame |
| trib_valid | input | 4 | A tributary bit is offered |
| trib_data | input | 4 | Tributary bit values |
| trib_ready | output | 4 | Store has room |
| force_ones | input | 4 | Replace a tributary's data with ones |
| aux_bit | input | 4 | Auxiliary bits for stuffed slots |
| alarm_bit | input | 1 | Bit 11 value |
| national_bit | input | 1 | Bit 12 value |
| out_valid | output | 1 | Output bit is valid |
| out_ready | input | 1 | Downstream takes the output bit |
| out_data | output | 1 | Serial frame bit |
| out_sync | output | 1 | High with the last bit of a frame |
| stuff_status | output | 4 | Stuff decision for the current frame |
| ovf_flag | output | 4 | Sticky store overflow |
| udf_flag | output | 4 | Sticky store underflow |

## Verification
A bit is chosen, and any store read it needs is made, on the edge that loads the output register. It appears on `out_data` and `out_sync` right after that edge. `stuff_status` changes on the same edge that loads bit 1. `trib_ready` and the sticky flags reflect the store state after the edge that wrote or read it. The bench therefore drives inputs at the falling edge and predicts the result of the next rising edge from its own frame position and a per-tributary bit-list model. It compares every output at the following falling edge, which is exactly one register after the stimulus.

// File: rtl/jm_pkg.sv
package jm_pkg;
  localparam int unsigned NTRIB   = 4;
  localparam int unsigned FAW_LEN = 10;
  // leftmost bit leaves first
  localparam logic [FAW_LEN-1:0] FAW_PATTERN = 10'b1111010000;

  typedef enum logic [2:0] {
    SLOT_FAW,
    SLOT_ALARM,
    SLOT_NAT,
    SLOT_DATA,
    SLOT_IND,
    SLOT_STUFF
  } slot_e;
endpackage

// File: rtl/jm_frame_timer.sv
module jm_frame_timer #(
  parameter int unsigned QUART_SHORT = 212,
  parameter int unsigned QUART_LONG  = 384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          mode_long_i,
  output jm_pkg::slot_e slot_kind,
  output logic [1:0]    slot_trib,
  output logic [3:0]    faw_idx,
  output logic          is_first,
  output logic          is_last
);
  import jm_pkg::*;

  localparam int unsigned OW = $clog2(QUART_LONG);
  localparam logic [OW-1:0] LAST_SHORT = OW'(QUART_SHORT - 1);
  localparam logic [OW-1:0] LAST_LONG  = OW'(QUART_LONG - 1);
  localparam logic [OW-1:0] HDR_ALARM  = OW'(FAW_LEN);
  localparam logic [OW-1:0] HDR_NAT    = OW'(FAW_LEN + 1);
  localparam logic [OW-1:0] GRP_END    = OW'(NTRIB);
  localparam logic [OW-1:0] STF_END    = OW'(2 * NTRIB);

  logic [1:0]    quart;
  logic [OW-1:0] offs;
  logic          long_q;
  logic          long_eff;
  logic [OW-1:0] last_offs;

  assign is_first  = (quart == 2'd0) && (offs == '0);
  assign long_eff  = is_first ? mode_long_i : long_q;
  assign last_offs = long_eff ? LAST_LONG : LAST_SHORT;
  assign is_last   = (quart == 2'd3) && (offs == last_offs);
  assign slot_trib = offs[1:0];
  assign faw_idx   = offs[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quart  <= '0;
      offs   <= '0;
      long_q <= 1'b0;
    end else if (advance) begin
      long_q <= long_eff;
      if (offs == last_offs) begin
        offs  <= '0;
        quart <= quart + 2'd1;
      end else begin
        offs <= offs + OW'(1);
      end
    end
  end

  always_comb begin
    slot_kind = SLOT_DATA;
    unique case (quart)
      2'd0: begin
        if (offs < HDR_ALARM)     slot_kind = SLOT_FAW;
        else if (offs == HDR_ALARM) slot_kind = SLOT_ALARM;
        else if (offs == HDR_NAT)   slot_kind = SLOT_NAT;
      end
      2'd1, 2'd2: begin
        if (offs < GRP_END) slot_kind = SLOT_IND;
      end
      default: begin
        if (offs < GRP_END)      slot_kind = SLOT_IND;
        else if (offs < STF_END) slot_kind = SLOT_STUFF;
      end
    endcase
  end

  // R1: after the last bit is taken, the next one opens a frame
  p_wrap_to_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && is_last) |=> is_first);
  // R1: the frame length is fixed between frame starts
  p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && is_first) |=> $stable(long_q));
  // R11: counters do not move without an advance
  p_no_drift_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(offs) && $stable(quart)));
endmodule

// File: rtl/jm_elastic_store.sv
module jm_elastic_store #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  output logic          rd_data,
  output logic [CW-1:0] fill,
  output logic          ovf,
  output logic          udf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wptr, rptr;
  logic             wr_ok, rd_ok;

  assign wr_ready = (fill != FULL);
  assign wr_ok    = wr_valid && wr_ready;
  assign rd_ok    = rd_en && (fill != '0);
  assign rd_data  = rd_ok ? mem[rptr] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem  <= '0;
      wptr <= AW'(DEPTH / 2);
      rptr <= '0;
      fill <= HALF;
      ovf  <= 1'b0;
      udf  <= 1'b0;
    end else begin
      if (wr_ok) begin
        mem[wptr] <= wr_data;
        wptr      <= wptr + AW'(1);
      end
      if (rd_ok) rptr <= rptr + AW'(1);
      fill <= fill + CW'(wr_ok) - CW'(rd_ok);
      if (wr_valid && !wr_ready) ovf <= 1'b1;
      if (rd_en && (fill == '0))  udf <= 1'b1;
    end
  end

  // R9: occupancy never exceeds the depth
  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);
  // R9: a refused bit leaves the fill untouched when nothing is read
  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !rd_en) |=> $stable(fill));
  // R9: overflow is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R10: underflow is sticky
  p_udf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    udf |=> udf);
endmodule

// File: rtl/jm_stuff_ctrl.sv
module jm_stuff_ctrl #(
  parameter int unsigned NT   = 4,
  parameter int unsigned CW   = 4,
  parameter int unsigned HALF = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  latch_en,
  input  logic [NT-1:0][CW-1:0] fill,
  output logic [NT-1:0]         stuff_q
);
  for (genvar i = 0; i < NT; i++) begin : g_dec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stuff_q[i] <= 1'b0;
      else if (latch_en) stuff_q[i] <= (fill[i] < CW'(HALF));
    end
  end

  // R7: decisions change only at a frame start
  p_decision_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(stuff_q));
endmodule

// File: rtl/jm_frame_mux.sv
module jm_frame_mux #(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned QUART_SHORT = 212,
  parameter int unsigned QUART_LONG  = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_long,
  input  logic [3:0] trib_valid,
  input  logic [3:0] trib_data,
  output logic [3:0] trib_ready,
  input  logic [3:0] force_ones,
  input  logic [3:0] aux_bit,
  input  logic       alarm_bit,
  input  logic       national_bit,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_data,
  output logic       out_sync,
  output logic [3:0] stuff_status,
  output logic [3:0] ovf_flag,
  output logic [3:0] udf_flag
);
  import jm_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH + 1);

  slot_e                    slot_kind;
  logic [1:0]               slot_trib;
  logic [3:0]               faw_idx;
  logic                     is_first, is_last;
  logic                     load;
  logic [NTRIB-1:0][CW-1:0] fill_w;
  logic [NTRIB-1:0]         rd_en_w, rd_data_w;
  logic [NTRIB-1:0]         stuff_q;
  logic                     data_bit, next_bit;

  assign load = !out_valid || out_ready;

  jm_frame_timer #(
    .QUART_SHORT(QUART_SHORT),
    .QUART_LONG (QUART_LONG)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (load),
    .mode_long_i(mode_long),
    .slot_kind  (slot_kind),
    .slot_trib  (slot_trib),
    .faw_idx    (faw_idx),
    .is_first   (is_first),
    .is_last    (is_last)
  );

  jm_stuff_ctrl #(
    .NT  (NTRIB),
    .CW  (CW),
    .HALF(DEPTH / 2)
  ) u_stuff (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch_en(load && is_first),
    .fill    (fill_w),
    .stuff_q (stuff_q)
  );

  for (genvar i = 0; i < NTRIB; i++) begin : g_trib
    assign rd_en_w[i] = load && (slot_trib == 2'(i)) &&
                        ((slot_kind == SLOT_DATA) ||
                         ((slot_kind == SLOT_STUFF) && !stuff_q[i]));

    jm_elastic_store #(.DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(trib_valid[i]),
      .wr_data (trib_data[i]),
      .wr_ready(trib_ready[i]),
      .rd_en   (rd_en_w[i]),
      .rd_data (rd_data_w[i]),
      .fill    (fill_w[i]),
      .ovf     (ovf_flag[i]),
      .udf     (udf_flag[i])
    );
  end

  assign data_bit = force_ones[slot_trib] ? 1'b1 : rd_data_w[slot_trib];

  always_comb begin
    next_bit = 1'b1;
    unique case (slot_kind)
      SLOT_FAW:   next_bit = FAW_PATTERN[4'(FAW_LEN - 1) - faw_idx];
      SLOT_ALARM: next_bit = alarm_bit;
      SLOT_NAT:   next_bit = national_bit;
      SLOT_IND:   next_bit = stuff_q[slot_trib];
      SLOT_STUFF: next_bit = stuff_q[slot_trib] ? aux_bit[slot_trib] : data_bit;
      default:    next_bit = data_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_sync  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= next_bit;
      out_sync  <= is_last;
    end
  end

  assign stuff_status = stuff_q;

  // R11: a stalled bit is held
  p_hold_on_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_sync)));
  // R11: valid never drops once raised
  p_valid_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
  // R4: two frame ends are never adjacent
  p_sync_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_sync) |=> !out_sync);
  // R5: at most one store is read per bit
  p_one_reader_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en_w));
endmodule

// File: tb/jm_frame_mux_tb.sv
module jm_frame_mux_tb;
  typedef struct packed {
    logic        mode;
    logic [3:0]  frc;
    logic [3:0]  aux;
    logic        alm;
    logic        nat;
    logic [1:0]  stall;
    logic [9:0]  r0, r1, r2, r3;
    logic [15:0] cycles;
  } vec_t;

  // rates are bits per 1024 clocks
  localparam vec_t VECS [8] = '{
    '{1'b0, 4'h0, 4'hA, 1'b1, 1'b0, 2'd0, 10'd248, 10'd248, 10'd248, 10'd248, 16'd1900},
    '{1'b0, 4'h0, 4'h5, 1'b0, 1'b1, 2'd0, 10'd200, 10'd300, 10'd248, 10'd260, 16'd1800},
    '{1'b1, 4'h4, 4'hF, 1'b1, 1'b1, 2'd0, 10'd252, 10'd252, 10'd252, 10'd252, 16'd3200},
    '{1'b1, 4'h0, 4'h3, 1'b0, 1'b0, 2'd1, 10'd190, 10'd190, 10'd200, 10'd180, 16'd2000},
    '{1'b0, 4'h0, 4'hC, 1'b1, 1'b0, 2'd0, 10'd248, 10'd240, 10'd256, 10'd248, 16'd1500},
    '{1'b0, 4'h0, 4'h9, 1'b0, 1'b1, 2'd0, 10'd400, 10'd400, 10'd248, 10'd248, 16'd1200},
    '{1'b1, 4'h0, 4'h6, 1'b1, 1'b1, 2'd0, 10'd252, 10'd252, 10'd252, 10'd0,   16'd1700},
    '{1'b0, 4'h9, 4'h1, 1'b0, 1'b0, 2'd2, 10'd120, 10'd130, 10'd120, 10'd125, 16'd2000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_long = 1'b0;
  logic [3:0] trib_valid = '0, trib_data = '0, force_ones = '0, aux_bit = '0;
  logic       alarm_bit = 1'b0, national_bit = 1'b0, out_ready = 1'b0;
  logic [3:0] trib_ready, stuff_status, ovf_flag, udf_flag;
  logic       out_valid, out_data, out_sync;

  always #2 clk = ~clk;

  jm_frame_mux u_dut (
    .clk(clk), .rst_n(rst_n), .mode_long(mode_long),
    .trib_valid(trib_valid), .trib_data(trib_data), .trib_ready(trib_ready),
    .force_ones(force_ones), .aux_bit(aux_bit), .alarm_bit(alarm_bit),
    .national_bit(national_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sync(out_sync), .stuff_status(stuff_status),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_buf [4];
  int         m_cnt [4];
  int         m_acc [4];
  int         m_wr  [4];
  logic [3:0] m_dec, m_ovf, m_udf;
  logic       m_valid, m_long, e_bit, e_sync;
  int         m_pos, e_pos, cyc;
  string      e_tag;

  task automatic chk(input logic act, input logic exp, input string tag, input int pos);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pos %0d actual=%b expected=%b", tag, pos, act, exp);
    end
  endtask

  task automatic chk4(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_buf[i] = 8'h00; m_cnt[i] = 4; m_acc[i] = 0; m_wr[i] = 0;
    end
    m_dec = '0; m_ovf = '0; m_udf = '0;
    m_valid = 1'b0; m_long = 1'b0; m_pos = 1; cyc = 0;
    e_bit = 1'b0; e_sync = 1'b0; e_pos = 0; e_tag = "R11";
  endtask

  function automatic logic pop(input int t);
    logic b;
    if (m_cnt[t] == 0) begin
      m_udf[t] = 1'b1;
      return 1'b1;
    end
    b = m_buf[t][0];
    m_buf[t] = m_buf[t] >> 1;
    m_cnt[t]--;
    return b;
  endfunction

  // compare the outputs produced by the last predicted edge
  task automatic check_outputs();
    chk(out_valid, m_valid, "R11 out_valid", e_pos);
    if (m_valid) begin
      chk(out_data, e_bit, e_tag, e_pos);
      chk(out_sync, e_sync, "R4 sync (R1 frame length)", e_pos);
    end
    chk4(stuff_status, m_dec, "R7 stuff_status");
    chk4(ovf_flag, m_ovf, "R9 overflow flag");
    chk4(udf_flag, m_udf, "R10 underflow flag");
    for (int i = 0; i < 4; i++)
      chk(trib_ready[i], m_cnt[i] != 8, "R9 trib_ready", i);
  endtask

  // drive inputs for the next rising edge and predict its result
  task automatic drive_predict(input vec_t v);
    logic   load;
    int     L, q, o, t, pre [4];
    logic   db;
    mode_long = v.mode; force_ones = v.frc; aux_bit = v.aux;
    alarm_bit = v.alm; national_bit = v.nat;
    out_ready = !((v.stall == 2'd1) && (cyc % 4 == 3)) && !((v.stall == 2'd2) && (cyc % 2 == 1));
    for (int i = 0; i < 4; i++) begin
      int r;
      r = (i == 0) ? int'(v.r0) : (i == 1) ? int'(v.r1) : (i == 2) ? int'(v.r2) : int'(v.r3);
      m_acc[i] += r;
      trib_valid[i] = (m_acc[i] >= 1024);
      if (trib_valid[i]) m_acc[i] -= 1024;
      trib_data[i] = m_wr[i][0] ^ m_wr[i][2] ^ (i == 1);
      pre[i] = m_cnt[i];
    end
    load = !m_valid || out_ready;
    if (load) begin
      if (m_pos == 1) begin
        m_long = mode_long;
        for (int i = 0; i < 4; i++) m_dec[i] = (m_cnt[i] < 4);
      end
      L = m_long ? 384 : 212;
      q = (m_pos - 1) / L;
      o = (m_pos - 1) % L;
      t = (m_pos - 1) % 4;
      e_pos = m_pos;
      if (q == 0 && o < 10) begin
        e_bit = 10'b1111010000 >> (9 - o); e_tag = "R2 alignment word";
      end else if (q == 0 && o == 10) begin
        e_bit = alarm_bit; e_tag = "R3 alarm bit";
      end else if (q == 0 && o == 11) begin
        e_bit = national_bit; e_tag = "R3 national bit";
      end else if (q != 0 && o < 4) begin
        e_bit = m_dec[t]; e_tag = "R6 indicator";
      end else if (q == 3 && o < 8 && m_dec[t]) begin
        e_bit = aux_bit[t]; e_tag = "R7 stuffed slot aux";
      end else begin
        db = pop(t);
        e_bit = force_ones[t] ? 1'b1 : db;
        e_tag = force_ones[t] ? "R8 forced data" : "R5 data";
      end
      e_sync = (m_pos == 4 * L);
      m_pos = e_sync ? 1 : m_pos + 1;
      m_valid = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      if (trib_valid[i]) begin
        if (pre[i] < 8) begin
          m_buf[i][m_cnt[i]] = trib_data[i];
          m_cnt[i]++;
          m_wr[i]++;
        end else begin
          m_ovf[i] = 1'b1;
        end
      end
    end
    cyc++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(out_valid, 1'b0, "R12 out_valid in reset", 0);
    chk(out_sync, 1'b0, "R12 out_sync in reset", 0);
    chk4(stuff_status, 4'h0, "R12 stuff_status in reset");
    chk4(ovf_flag | udf_flag, 4'h0, "R12 flags in reset");
    chk4(trib_ready, 4'hF, "R12 trib_ready in reset");
    rst_n = 1'b1;
    drive_predict(VECS[0]);
    for (int v = 0; v < 8; v++) begin
      for (int c = 0; c < int'(VECS[v].cycles); c++) begin
        @(negedge clk);
        check_outputs();
        drive_predict(VECS[v]);
      end
    end
    // R9/R10: the heavy vectors must have left sticky flags behind
    chk(ovf_flag[0], 1'b1, "R9 sticky overflow after fast tributary", 0);
    chk(udf_flag[3], 1'b1, "R10 sticky underflow after silent tributary", 3);
    // mid-run reset, then restart with a nominal stream
    @(negedge clk);
    rst_n = 1'b0;
    trib_valid = '0;
    @(negedge clk);
    chk(out_valid, 1'b0, "R12 out_valid after re-reset", 0);
    chk4(stuff_status, 4'h0, "R12 stuff_status after re-reset");
    chk4(ovf_flag | udf_flag, 4'h0, "R12 flags after re-reset");
    chk4(trib_ready, 4'hF, "R12 trib_ready after re-reset");
    model_reset();
    rst_n = 1'b1;
    drive_predict(VECS[4]);
    for (int c = 0; c < 1800; c++) begin
      @(negedge clk);
      check_outputs();
      drive_predict(VECS[4]);
    end
    @(negedge clk);
    check_outputs();
    finish_run();
  end
endmodule